// File: doc/BRIEF.md
# Pin Bank with Polarity-Aware Interrupts

This block is a 32-pin general-purpose I/O bank sitting behind a simple synchronous register bus with a byte address, a write strobe, write data and combinational read data. For each pin it holds an output level, a direction bit, a blink enable and an input-inversion bit. It drives the pad output enables and output levels. A pin with blink enabled drives a free-running square wave. Pad inputs are brought into the clock domain through a two-flop synchronizer. They are then optionally inverted, and the result is the pin's data-in value.

Interrupts come from two sources. A level source follows data-in directly. An edge source latches rising transitions of data-in into a sticky cause register. Each source has its own per-pin mask. Because inversion is applied before both detectors, software picks active-high or active-low level sensing, and rising or falling edge sensing, with one bit. The masked causes of each group of eight consecutive pins are ORed into one of four group interrupt lines for a main interrupt controller.

Top module: `pio_bank`

## Requirements
- R1: After a synchronous active-low reset every register is zero: all pins are outputs driving low (`pad_oe` all ones, `pad_out` zero), every mask is clear, no edge is pending and `irq_grp` is zero.
- R2: Registers are decoded at byte addresses 0x00 output level, 0x04 direction, 0x08 blink enable, 0x0C input inversion, 0x10 data-in (read-only), 0x14 edge cause, 0x18 edge mask and 0x1C level mask. Any other address reads zero. A write to 0x10 or to an unused address changes nothing.
- R3: A direction bit of 1 makes the pin an input, with `pad_oe` low and `pad_out` low. A direction bit of 0 makes it an output, with `pad_oe` high.
- R4: Data-in bit i equals pad input i, delayed through two flops, XORed with inversion bit i. A pad change is readable at 0x10 after the second rising clock edge and not after the first.
- R5: The level source of pin i is data-in bit i ANDed with level-mask bit i.
- R6: A 0-to-1 transition of data-in bit i sets edge-cause bit i at the next clock edge. A 1-to-0 transition does not set it. With the inversion bit set, a falling pad therefore sets the cause bit.
- R7: A write to 0x14 clears each cause bit whose write-data bit is 0 and keeps each bit whose write-data bit is 1. Without such a write, cause bits stay set. A rising transition in the same cycle as a clearing write leaves the bit set.
- R8: `irq_grp[g]` is the OR over pins 8g to 8g+7 of (level source OR (edge-cause bit AND edge-mask bit)).
- R9: An output pin with blink enabled drives a phase signal instead of its output-level bit. The phase is low after reset and inverts every `BLINK_HALF` clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, the write happens at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_oe | output | 32 | Pad output enables, high for output pins |
| pad_out | output | 32 | Pad output levels |
| irq_grp | output | 4 | One interrupt line per group of eight pins |

## Verification
The assertions check properties that hold on every cycle. A pin that is not driven drives low. A set edge-cause bit survives any cycle without a cause write. Every rising transition of data-in lands in the cause register. A group line can only be high while some mask bit is set. The blink phase changes only when its counter wraps. The bench's scenarios show the rest: the exact two-cycle synchronizer latency, how inversion turns a falling pad into an edge, partial clearing of the cause register, a clearing write that collides with a new edge, the mapping of pins to group lines, and the blink half period measured at the pad. A behavioural model checks the pad and interrupt outputs on every clock alongside these scenarios.

// File: rtl/pio_pkg.sv
// Package: register addresses shared by the pin bank and its bench.
// Assumes a 5-bit byte address; only word-aligned addresses decode.
package pio_pkg;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] A_LEVEL  = 5'h00;
    localparam logic [ADDR_W-1:0] A_DIR    = 5'h04;
    localparam logic [ADDR_W-1:0] A_BLINK  = 5'h08;
    localparam logic [ADDR_W-1:0] A_INVERT = 5'h0C;
    localparam logic [ADDR_W-1:0] A_DIN    = 5'h10;
    localparam logic [ADDR_W-1:0] A_CAUSE  = 5'h14;
    localparam logic [ADDR_W-1:0] A_EMASK  = 5'h18;
    localparam logic [ADDR_W-1:0] A_LMASK  = 5'h1C;
endpackage

// File: rtl/pio_sync.sv
// Module: two-flop synchronizer for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherence is implied.
module pio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two register stages, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/pio_blink.sv
// Module: free-running blink phase generator.
// The phase starts low at reset and inverts every HALF clock cycles.
// Assumes HALF >= 1.
module pio_blink #(
    parameter int HALF = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles within a half period and flip the phase on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_phase_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != LAST) |=> $stable(phase))
        else $error("blink phase changed before its counter wrapped");
endmodule

// File: rtl/pio_irq.sv
// Module: edge capture, per-source masking and group reduction.
// data_in is already synchronized and inverted where requested.
// Assumes NPIN is a multiple of GRP.
module pio_irq #(
    parameter int NPIN = 32,
    parameter int GRP  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPIN-1:0]     data_in,
    input  logic                cause_we,
    input  logic [NPIN-1:0]     cause_wdata,
    input  logic [NPIN-1:0]     edge_en,
    input  logic [NPIN-1:0]     lvl_en,
    output logic [NPIN-1:0]     edge_pend,
    output logic [NPIN/GRP-1:0] irq_grp
);
    localparam int NGRP = NPIN / GRP;

    logic [NPIN-1:0] prev_q;
    logic [NPIN-1:0] rise;
    logic [NPIN-1:0] pin_cause;

    assign rise = data_in & ~prev_q;

    // Remember data-in and accumulate rising events; new events win over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            edge_pend <= '0;
        end else begin
            prev_q    <= data_in;
            edge_pend <= (cause_we ? (edge_pend & cause_wdata) : edge_pend) | rise;
        end
    end

    // Per-pin cause: masked level OR masked pending edge.
    always_comb begin
        pin_cause = (data_in & lvl_en) | (edge_pend & edge_en);
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign irq_grp[g] = |pin_cause[g*GRP +: GRP];
    end

    p_edge_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cause_we |=> (($past(edge_pend) & ~edge_pend) == '0))
        else $error("pending edge lost without a clearing write");

    p_rise_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> (($past(rise) & ~edge_pend) == '0))
        else $error("rising data-in not captured");
endmodule

// File: rtl/pio_bank.sv
// Module: 32-pin I/O bank top: register file, read mux, pad drive.
// Assumes bus_rdata is sampled by the master in the same cycle as bus_addr.
module pio_bank #(
    parameter int NPIN       = 32,
    parameter int GRP        = 8,
    parameter int BLINK_HALF = 5_000_000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [pio_pkg::ADDR_W-1:0]    bus_addr,
    input  logic                          bus_we,
    input  logic [NPIN-1:0]               bus_wdata,
    output logic [NPIN-1:0]               bus_rdata,
    input  logic [NPIN-1:0]               pad_in,
    output logic [NPIN-1:0]               pad_oe,
    output logic [NPIN-1:0]               pad_out,
    output logic [NPIN/GRP-1:0]           irq_grp
);
    import pio_pkg::*;

    logic [NPIN-1:0] level_q, dir_q, blink_q, inv_q, emask_q, lmask_q;
    logic [NPIN-1:0] sync_in, data_in, edge_pend;
    logic            phase;
    logic            cause_we;

    assign cause_we = bus_we && (bus_addr == A_CAUSE);
    assign data_in  = sync_in ^ inv_q;

    // Configuration registers, written at the clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            dir_q   <= '0;
            blink_q <= '0;
            inv_q   <= '0;
            emask_q <= '0;
            lmask_q <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                A_LEVEL:  level_q <= bus_wdata;
                A_DIR:    dir_q   <= bus_wdata;
                A_BLINK:  blink_q <= bus_wdata;
                A_INVERT: inv_q   <= bus_wdata;
                A_EMASK:  emask_q <= bus_wdata;
                A_LMASK:  lmask_q <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Read mux; data-in and cause are live, unused addresses read zero.
    always_comb begin
        case (bus_addr)
            A_LEVEL:  bus_rdata = level_q;
            A_DIR:    bus_rdata = dir_q;
            A_BLINK:  bus_rdata = blink_q;
            A_INVERT: bus_rdata = inv_q;
            A_DIN:    bus_rdata = data_in;
            A_CAUSE:  bus_rdata = edge_pend;
            A_EMASK:  bus_rdata = emask_q;
            A_LMASK:  bus_rdata = lmask_q;
            default:  bus_rdata = '0;
        endcase
    end

    // Pad drive: inputs float low, blinking outputs follow the phase.
    always_comb begin
        pad_oe  = ~dir_q;
        pad_out = ~dir_q & ((blink_q & {NPIN{phase}}) | (~blink_q & level_q));
    end

    pio_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (sync_in)
    );

    pio_blink #(.HALF(BLINK_HALF)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    pio_irq #(.NPIN(NPIN), .GRP(GRP)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_in     (data_in),
        .cause_we    (cause_we),
        .cause_wdata (bus_wdata),
        .edge_en     (emask_q),
        .lvl_en      (lmask_q),
        .edge_pend   (edge_pend),
        .irq_grp     (irq_grp)
    );

    p_input_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0))
        else $error("input pin drives a high level");

    p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_grp != '0) |-> ((emask_q | lmask_q) != '0))
        else $error("group interrupt with every mask clear");
endmodule

// File: tb/pio_bank_test.sv
module pio_bank_test;
    import pio_pkg::*;

    localparam int HALF = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_oe, pad_out;
    logic [3:0]  irq_grp;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pio_bank #(.BLINK_HALF(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .irq_grp(irq_grp)
    );

    // Behavioural reference model, updated at each rising edge.
    logic [31:0] m_lvl, m_dir, m_blk, m_inv, m_cause, m_em, m_lm, m_s1, m_s2, m_prev;
    int          m_cnt;
    logic        m_ph;
    bit          m_ok = 0;

    always @(posedge clk) begin
        logic [31:0] adj;
        if (!rst_n) begin
            {m_lvl, m_dir, m_blk, m_inv, m_cause, m_em, m_lm} = '0;
            {m_s1, m_s2, m_prev} = '0;
            m_cnt = 0; m_ph = 0; m_ok = 1;
        end else begin
            adj = m_s2 ^ m_inv;
            if (bus_we && bus_addr == A_CAUSE) m_cause = m_cause & bus_wdata;
            m_cause = m_cause | (adj & ~m_prev);
            m_prev = adj;
            m_s2 = m_s1;
            m_s1 = pad_in;
            if (bus_we) begin
                if (bus_addr == A_LEVEL)  m_lvl = bus_wdata;
                if (bus_addr == A_DIR)    m_dir = bus_wdata;
                if (bus_addr == A_BLINK)  m_blk = bus_wdata;
                if (bus_addr == A_INVERT) m_inv = bus_wdata;
                if (bus_addr == A_EMASK)  m_em  = bus_wdata;
                if (bus_addr == A_LMASK)  m_lm  = bus_wdata;
            end
            if (m_cnt == HALF - 1) begin m_cnt = 0; m_ph = ~m_ph; end
            else m_cnt = m_cnt + 1;
        end
    end

    function automatic logic [3:0] exp_grp();
        logic [31:0] c;
        logic [3:0]  r;
        c = ((m_s2 ^ m_inv) & m_lm) | (m_cause & m_em);
        for (int g = 0; g < 4; g++) r[g] = |c[g*8 +: 8];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Compare pad and interrupt outputs with the model on every clock.
    always @(negedge clk) begin
        if (rst_n && m_ok) begin
            chk("R3 oe", pad_oe, ~m_dir);
            chk("R9 R3 out", pad_out, ~m_dir & ((m_blk & {32{m_ph}}) | (~m_blk & m_lvl)));
            chk("R8 grp", {28'd0, irq_grp}, {28'd0, exp_grp()});
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        @(negedge clk);
        chk(req, bus_rdata, exp);
        #1;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        logic v;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        @(negedge clk);
        chk("R1 oe", pad_oe, 32'hFFFF_FFFF);
        chk("R1 out", pad_out, '0);
        chk("R1 irq", {28'd0, irq_grp}, '0);
        #1;
        rd(A_DIR, '0, "R1 dir");
        rd(A_CAUSE, '0, "R1 cause");
        rd(A_LMASK, '0, "R1 lmask");

        // R2: register map, read-only and unused addresses
        wr(A_LEVEL, 32'h1234_5678);  rd(A_LEVEL, 32'h1234_5678, "R2 level");
        wr(A_BLINK, 32'h0F0F_0000);  rd(A_BLINK, 32'h0F0F_0000, "R2 blink");
        wr(A_EMASK, 32'h00FF_00FF);  rd(A_EMASK, 32'h00FF_00FF, "R2 emask");
        wr(A_DIN, 32'hFFFF_FFFF);    rd(A_DIN, '0, "R2 din ro");
        wr(5'h05, 32'hFFFF_FFFF);    rd(A_DIR, '0, "R2 unused write");
        rd(5'h02, '0, "R2 unused read");
        wr(A_BLINK, '0);
        wr(A_EMASK, '0);

        // R3: direction split
        wr(A_DIR, 32'h0000_FFFF);
        wr(A_LEVEL, 32'hA5A5_A5A5);
        @(negedge clk);
        chk("R3 oe", pad_oe, 32'hFFFF_0000);
        chk("R3 out", pad_out, 32'hA5A5_0000);
        #1;

        // R4: two-flop latency and inversion
        wr(A_DIR, 32'hFFFF_FFFF);
        wr(A_INVERT, 32'h0000_00F0);
        pad_in = 32'h8000_0011;
        @(posedge clk); #1;
        rd(A_DIN, 32'h0000_00F0, "R4 one edge");
        @(posedge clk); #1;
        rd(A_DIN, 32'h8000_00E1, "R4 two edges");

        // R5: level source through level mask (pin 31 high -> group 3)
        wr(A_LMASK, 32'h8000_0000);
        @(negedge clk);
        chk("R5 level", {28'd0, irq_grp}, 32'h8);
        #1;
        wr(A_LMASK, '0);

        // R6: edges; clear cause, then falling pad with inversion set
        wr(A_CAUSE, '0);
        wr(A_INVERT, '0);
        wr(A_CAUSE, '0);
        cyc(3);
        wr(A_CAUSE, '0);
        rd(A_CAUSE, '0, "R6 clear base");
        pad_in = 32'h8000_0010;      // pin 0 falls: no edge
        cyc(4);
        rd(A_CAUSE, '0, "R6 fall ignored");
        wr(A_INVERT, 32'h0000_0100);  // pin 8 inverted, pad low -> rises now
        cyc(1);
        rd(A_CAUSE, 32'h0000_0100, "R6 invert rise");
        pad_in = 32'h8000_0210;       // pin 9 rises
        cyc(4);
        rd(A_CAUSE, 32'h0000_0300, "R6 rise");

        // R7: partial clear
        wr(A_CAUSE, 32'h0000_0200);
        rd(A_CAUSE, 32'h0000_0200, "R7 partial clear");
        // R8: edge mask on group 1
        wr(A_EMASK, 32'h0000_0200);
        @(negedge clk);
        chk("R8 edge group", {28'd0, irq_grp}, 32'h2);
        #1;
        wr(A_EMASK, 32'h0000_0100);
        @(negedge clk);
        chk("R8 masked off", {28'd0, irq_grp}, 32'h0);
        #1;
        wr(A_EMASK, '0);

        // R7: clearing write collides with a new edge on pin 20
        pad_in = 32'h8010_0210;
        @(posedge clk);
        @(posedge clk); #1;
        bus_addr = A_CAUSE; bus_we = 1'b1; bus_wdata = '0;
        @(posedge clk); #1;
        bus_we = 1'b0;
        rd(A_CAUSE, 32'h0010_0000, "R7 edge wins");
        wr(A_CAUSE, '0);
        rd(A_CAUSE, '0, "R7 clear all");

        // R9: blink on output pins
        wr(A_DIR, 32'hFFFF_FFFC);
        wr(A_LEVEL, 32'h0000_0003);
        wr(A_BLINK, 32'h0000_0001);
        @(negedge clk);
        v = pad_out[0];
        chk("R9 level pin", {31'd0, pad_out[1]}, 32'h1);
        repeat (HALF) @(negedge clk);
        chk("R9 half period", {31'd0, pad_out[0]}, {31'd0, ~v});
        repeat (HALF) @(negedge clk);
        chk("R9 full period", {31'd0, pad_out[0]}, {31'd0, v});
        #1;
        wr(A_DIR, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R9 R3 input blink", pad_out, '0);
        cyc(2 * HALF);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule